// File: doc/BRIEF.md
# Trimmable Carrier Sample Timebase

This block turns a fast system clock into the pacing signals for a table-driven audio carrier. A reloadable down-counter produces a base tick. Its reload value is a fixed base plus a small trim code, which moves every downstream rate by a few percent. A fixed number of base ticks forms the fastest sample interval. A rate selector stretches that interval by one, two or four, which gives the three carrier sample rates.

Each completed interval produces a one-cycle sample strobe and a phase index for the waveform table that follows. Once every full carrier cycle of 2^PHASE_W samples, the block also produces a cycle strobe. Trim and rate changes never cut an interval short. The trim is sampled when the counter reloads, and the rate is sampled when a sample interval begins.

Top module: `smp_timebase`

## Requirements
- R1: With a steady trim code `t`, the base tick period is `P = PRESET_BASE + t` clock cycles (194 to 209 with the default parameters).
- R2: Rate code 2'b00 gives a sample interval of TICKS_PER_BASE·1 ticks, 2'b01 gives TICKS_PER_BASE·2 ticks and 2'b10 gives TICKS_PER_BASE·4 ticks. With steady inputs, the sample strobes are therefore `TICKS_PER_BASE·D·P` cycles apart.
- R3: Rate code 2'b11 behaves exactly like 2'b10 (divide by 4).
- R4: The trim input is read only when the counter reloads. A new code first governs the tick that starts at the next reload. A trim excursion that starts and ends between two reloads has no effect on any strobe timing.
- R5: The rate code is read only when an interval begins: at the first clock after reset and at the edge that raises each sample strobe. A change applied after a strobe takes effect one interval later.
- R6: While reset is high, both strobes and the phase index are zero. The first sample strobe appears on the output after clock edge number `TICKS_PER_BASE·D·P + 1`, counting the first rising edge with reset low as edge 1. That first strobe carries phase index 0.
- R7: The sample strobe is exactly one clock cycle wide.
- R8: Each sample strobe carries a phase index one greater than the previous one, wrapping from 2^PHASE_W−1 to 0. The index holds its value between strobes.
- R9: The cycle strobe is high exactly in the cycles where the sample strobe is high and the phase index is 2^PHASE_W−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| trim_i | input | TRIM_W | Trim code added to PRESET_BASE to form the reload value |
| rsel_i | input | 2 | Rate select: 00 fastest, 01 half, 10 or 11 quarter |
| smp_stb_o | output | 1 | One-cycle strobe per carrier sample |
| phase_o | output | PHASE_W | Table index of the current sample |
| cyc_stb_o | output | 1 | Strobe on the last sample of each carrier cycle |

## Verification
The hardest behaviour to provoke from the ports is a trim change whose effect depends on where it lands relative to an internal reload. The counter itself is hidden, so the only reliable reference points are the observed sample strobes. The bench therefore times every trim and rate change from the cycle just after a strobe, where the reload that just happened used the old value. Each expected interval is then split into one tick at the old period and the remaining ticks at the new one. Short trim excursions are also placed inside the first tick, shorter than that tick, and then withdrawn; with a random mix of trim and rate codes, these show that an excursion never reaches the strobe spacing.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

    typedef enum logic [1:0] {
        RSEL_FULL    = 2'b00,
        RSEL_HALF    = 2'b01,
        RSEL_QUARTER = 2'b10,
        RSEL_QALIAS  = 2'b11
    } rsel_e;

    // Ticks per sample interval for a rate code, given the ticks in the
    // fastest interval.
    function automatic int unsigned ticks_per_sample(input logic [1:0] rsel,
                                                     input int unsigned base_ticks);
        int unsigned mult;
        case (rsel_e'(rsel))
            RSEL_FULL:    mult = 1;
            RSEL_HALF:    mult = 2;
            RSEL_QUARTER: mult = 4;
            default:      mult = 4;
        endcase
        return base_ticks * mult;
    endfunction

endpackage

// File: rtl/sbt_tick_gen.sv
module sbt_tick_gen #(
    parameter int CNT_W       = 8,
    parameter int TRIM_W      = 4,
    parameter int PRESET_BASE = 194
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [TRIM_W-1:0] trim_i,
    output logic              tick_o,
    output logic              arm_o
);

    localparam int             MAX_PRESET = PRESET_BASE + (1 << TRIM_W) - 1;
    localparam logic [CNT_W-1:0] BASE_L   = CNT_W'(PRESET_BASE);
    localparam logic [CNT_W-1:0] ONE_L    = CNT_W'(1);

    generate
        if (MAX_PRESET >= (1 << CNT_W) || PRESET_BASE < 1) begin : g_bad_cfg
            $error("sbt_tick_gen: preset range does not fit the counter");
        end
    endgenerate

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic [CNT_W-1:0] reload_val;
    logic             is_arm;
    logic             is_last;

    always_comb begin
        st_d       = st_q;
        reload_val = BASE_L + CNT_W'(trim_i);
        // A zero count exists only right after reset: load without a tick.
        is_arm     = (st_q.cnt == '0);
        is_last    = (st_q.cnt == ONE_L);
        if (is_arm || is_last) begin
            st_d.cnt = reload_val;
        end else begin
            st_d.cnt = st_q.cnt - ONE_L;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = is_last;
    assign arm_o  = is_arm;

endmodule

// File: rtl/sbt_rate_div.sv
module sbt_rate_div
    import sbt_pkg::*;
#(
    parameter int TICKS_PER_BASE = 2,
    parameter int DIV_W          = 4
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       arm_i,
    input  logic       tick_i,
    input  logic [1:0] rsel_i,
    output logic       done_o
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [1:0]       rsel;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DIV_W-1:0] last_tick;
    logic             done;

    always_comb begin
        st_d      = st_q;
        last_tick = DIV_W'(ticks_per_sample(st_q.rsel, TICKS_PER_BASE) - 1);
        done      = tick_i && (st_q.div == last_tick);
        if (arm_i) begin
            st_d.div  = '0;
            st_d.rsel = rsel_i;
        end else if (done) begin
            st_d.div  = '0;
            st_d.rsel = rsel_i;
        end else if (tick_i) begin
            st_d.div  = st_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = done;

endmodule

// File: rtl/sbt_phase.sv
module sbt_phase #(
    parameter int PHASE_W = 6
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               done_i,
    output logic               smp_o,
    output logic [PHASE_W-1:0] phase_o,
    output logic               cyc_o
);

    localparam logic [PHASE_W-1:0] LAST_IDX = '1;

    typedef struct packed {
        logic [PHASE_W-1:0] idx;
        logic [PHASE_W-1:0] phase;
        logic               smp;
        logic               cyc;
    } ph_st_t;

    ph_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.smp = 1'b0;
        st_d.cyc = 1'b0;
        if (done_i) begin
            st_d.smp   = 1'b1;
            st_d.phase = st_q.idx;
            st_d.cyc   = (st_q.idx == LAST_IDX);
            st_d.idx   = st_q.idx + PHASE_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign smp_o   = st_q.smp;
    assign phase_o = st_q.phase;
    assign cyc_o   = st_q.cyc;

endmodule

// File: rtl/smp_timebase.sv
module smp_timebase #(
    parameter int CNT_W          = 8,
    parameter int TRIM_W         = 4,
    parameter int PRESET_BASE    = 194,
    parameter int TICKS_PER_BASE = 2,
    parameter int PHASE_W        = 6
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [TRIM_W-1:0]  trim_i,
    input  logic [1:0]         rsel_i,
    output logic               smp_stb_o,
    output logic [PHASE_W-1:0] phase_o,
    output logic               cyc_stb_o
);

    localparam int DIV_W = $clog2(4 * TICKS_PER_BASE) + 1;

    logic tick;
    logic arm;
    logic done;

    sbt_tick_gen #(
        .CNT_W      (CNT_W),
        .TRIM_W     (TRIM_W),
        .PRESET_BASE(PRESET_BASE)
    ) u_tick (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .trim_i(trim_i),
        .tick_o(tick),
        .arm_o (arm)
    );

    sbt_rate_div #(
        .TICKS_PER_BASE(TICKS_PER_BASE),
        .DIV_W         (DIV_W)
    ) u_div (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .arm_i (arm),
        .tick_i(tick),
        .rsel_i(rsel_i),
        .done_o(done)
    );

    sbt_phase #(
        .PHASE_W(PHASE_W)
    ) u_phase (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .done_i (done),
        .smp_o  (smp_stb_o),
        .phase_o(phase_o),
        .cyc_o  (cyc_stb_o)
    );

endmodule

// File: rtl/sbt_checker.sv
module sbt_checker #(
    parameter int PHASE_W = 6
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               smp_stb_o,
    input logic [PHASE_W-1:0] phase_o,
    input logic               cyc_stb_o
);

    localparam logic [PHASE_W-1:0] TOP_IDX = '1;

    logic seen_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            seen_q <= 1'b0;
        end else if (smp_stb_o) begin
            seen_q <= 1'b1;
        end
    end

    a_r7_one_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
        smp_stb_o |=> !smp_stb_o);

    a_r9_cyc_on_last: assert property (@(posedge clk_i) disable iff (rst_i)
        cyc_stb_o |-> (smp_stb_o && phase_o == TOP_IDX));

    a_r9_last_has_cyc: assert property (@(posedge clk_i) disable iff (rst_i)
        (smp_stb_o && phase_o == TOP_IDX) |-> cyc_stb_o);

    a_r8_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !smp_stb_o |-> $stable(phase_o));

    a_r8_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (smp_stb_o && seen_q) |-> (phase_o == PHASE_W'($past(phase_o) + 1'b1)));

    a_r6_first_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (smp_stb_o && !seen_q) |-> (phase_o == '0));

endmodule

bind smp_timebase sbt_checker #(.PHASE_W(PHASE_W)) u_sbt_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .smp_stb_o(smp_stb_o),
    .phase_o  (phase_o),
    .cyc_stb_o(cyc_stb_o)
);

// File: tb/smp_timebase_bench.sv
`timescale 1ns/1ps
module smp_timebase_bench;

    localparam int CNT_W   = 8;
    localparam int TRIM_W  = 4;
    localparam int PB      = 3;
    localparam int TPB     = 2;
    localparam int PHASE_W = 6;

    logic               clk = 1'b0;
    logic               rst;
    logic [TRIM_W-1:0]  trim;
    logic [1:0]         rate;
    logic               smp;
    logic [PHASE_W-1:0] phase;
    logic               cyc;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_idx = 0;
    int last_phase = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    smp_timebase #(
        .CNT_W(CNT_W), .TRIM_W(TRIM_W), .PRESET_BASE(PB),
        .TICKS_PER_BASE(TPB), .PHASE_W(PHASE_W)
    ) u_smp_timebase (
        .clk_i(clk), .rst_i(rst), .trim_i(trim), .rsel_i(rate),
        .smp_stb_o(smp), .phase_o(phase), .cyc_stb_o(cyc)
    );

    function automatic int p_of(input logic [TRIM_W-1:0] t);
        return PB + int'(t);
    endfunction

    function automatic int d_of(input logic [1:0] r);
        if (r == 2'b00) return 1;
        if (r == 2'b01) return 2;
        return 4;
    endfunction

    function automatic int gap_of(input int pf, input int d, input int pr);
        return pf + (TPB * d - 1) * pr;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic strobe_checks();
        chk(int'(phase) == exp_idx, "R8 phase index", int'(phase), exp_idx);
        chk(cyc == (exp_idx == 63), "R9 cycle strobe", int'(cyc), int'(exp_idx == 63));
        last_phase = int'(phase);
        exp_idx = (exp_idx + 1) % 64;
    endtask

    // Applies new codes right after a strobe and measures the next interval.
    task automatic step(input logic [TRIM_W-1:0] nt, input logic [1:0] nr,
                        input int glitch, input string tag);
        int pf;
        int d;
        int pr;
        int cnt;
        int expv;
        pf  = p_of(trim);
        d   = d_of(rate);
        pr  = p_of(nt);
        cnt = 0;
        rate = nr;
        trim = (glitch > 0) ? (nt ^ 4'b1010) : nt;
        forever begin
            @(posedge clk);
            #1;
            cnt++;
            if (glitch > 0 && cnt == glitch) trim = nt;
            if (cnt == 1) begin
                chk(!smp, "R7 strobe width", int'(smp), 0);
                chk(int'(phase) == last_phase, "R8 phase hold", int'(phase), last_phase);
            end
            if (smp || cnt > 5000) break;
        end
        expv = gap_of(pf, d, pr);
        chk(cnt == expv, tag, cnt, expv);
        strobe_checks();
    endtask

    initial begin
        int cnt;
        int expv;
        void'($urandom(32'd20240611));
        rst  = 1'b1;
        trim = 4'd5;
        rate = 2'b01;
        repeat (4) @(posedge clk);
        #1;
        chk(!smp, "R6 reset strobe", int'(smp), 0);
        chk(!cyc, "R6 reset cycle strobe", int'(cyc), 0);
        chk(phase == '0, "R6 reset phase", int'(phase), 0);
        rst = 1'b0;
        cnt = 0;
        forever begin
            @(posedge clk);
            #1;
            cnt++;
            if (smp || cnt > 5000) break;
        end
        expv = TPB * d_of(rate) * p_of(trim) + 1;
        chk(cnt == expv, "R6 first strobe edge", cnt, expv);
        chk(phase == '0, "R6 first phase", int'(phase), 0);
        strobe_checks();

        // Directed: steady rates, rate changes one interval late, alias code.
        step(4'd5, 2'b01, 0, "R2 steady half");
        step(4'd5, 2'b00, 0, "R5 rate change deferred");
        step(4'd5, 2'b00, 0, "R2 full rate");
        step(4'd5, 2'b10, 0, "R5 rate change deferred");
        step(4'd5, 2'b10, 0, "R2 quarter rate");
        step(4'd5, 2'b11, 0, "R3 alias entry");
        step(4'd5, 2'b11, 0, "R3 alias quarter");
        // Trim boundary values and reload timing.
        step(4'd15, 2'b00, 0, "R4 trim at reload");
        step(4'd15, 2'b00, 0, "R1 max trim");
        step(4'd0, 2'b00, 0, "R4 trim at reload");
        step(4'd0, 2'b00, 0, "R1 min trim");
        step(4'd0, 2'b00, 2, "R4 trim excursion");
        step(4'd9, 2'b01, 1, "R4 trim excursion");

        // Random mix covering phase wrap several times.
        for (int i = 0; i < 170; i++) begin
            logic [TRIM_W-1:0] nt;
            logic [1:0]        nr;
            int                gl;
            nt = TRIM_W'($urandom % 16);
            nr = 2'($urandom % 4);
            gl = 0;
            if ($urandom % 3 == 0) gl = 1 + int'($urandom % (p_of(trim) - 1));
            if (gl > 0 || nt != trim)
                step(nt, nr, gl, "R4 random trim");
            else if (nr != rate)
                step(nt, nr, 0, "R5 random rate");
            else
                step(nt, nr, 0, (nr == 2'b11) ? "R3 random" : "R1 random steady");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule